// File: doc/BRIEF.md
# Synchronous Output Clock Stop Gate

This block sits between a clock source and the output drivers of a clock generator and removes clock pulses on request without ever producing a shortened or lengthened pulse. It handles two groups of outputs. The first is a set of fast true/complement pairs. The second is a slower bus clock group, made of plain bus outputs plus a few outputs that can run freely. All logic runs on one reference clock `clk`. The two source clocks arrive as sampled levels (`cpu_src`, `bus_src`), and every output is a registered copy of its source, gated as needed.

For the pairs, an active-low stop request is captured on successive falling edges of the fast source. Each pair then either stops or keeps running, depending on its own free-run bit. A stopped pair rests at true-high/complement-low, or releases its output enable when the shared tri-state-on-stop bit is set. For the bus group, the effective stop is the AND of an external active-low pin and a register bit. That value is captured on the rising edge of the bus source, and stopped outputs rest low. The gate of each output is only allowed to change while its source sits at the resting level. As a result, an output that is stopping always finishes the phase it is in.

Top module: `clkstop_gate`

## Requirements
- R1: A pair stops only after `cpu_stop_n` has been seen low at two successive falling edges of `cpu_src` (an edge being a cycle where `cpu_src` is 0 after a cycle where it was 1). From the next high phase of `cpu_src`, a stoppable, enabled pair holds `cpu_t`=1 and `cpu_c`=0.
- R2: A pair whose `cpu_free` bit is 1 ignores the stop request. It keeps `cpu_t` equal to `cpu_src` and `cpu_c` equal to its inverse, each delayed by one `clk` cycle.
- R3: When `cpu_tri_stop` is 1, a stopped enabled pair drives `cpu_oe`=0. When it is 0, a stopped pair keeps `cpu_oe`=1.
- R4: After `cpu_stop_n` returns high, a stopped pair resumes on the first high phase of `cpu_src` that follows the second falling-edge sample of the high level.
- R5: The run/stop state of a pair changes only in a cycle where `cpu_src` is 1. The state of the bus group changes only in a cycle where `bus_src` is 0. No output pulse is ever cut short or lengthened.
- R6: A pair whose `cpu_en` bit is 0 drives `cpu_t`=0, `cpu_c`=0 and `cpu_oe`=0, whatever the stop state.
- R7: The effective bus stop is `bus_stop_pin_n` AND `bus_stop_reg`. It is sampled once at each rising edge of `bus_src`. When the sampled value is 0, all `bus_out` bits are held low from the next low phase of `bus_src`.
- R8: A `free_out` bit whose `free_stoppable` bit is 0 always follows `bus_src`. A bit whose `free_stoppable` bit is 1 stops low together with `bus_out`.
- R9: After the effective bus stop returns to 1, stopped bus outputs produce their first high pulse no more than two `bus_src` periods after the rising edge that samples the change.
- R10: A 0 in `bus_en` or `free_en` forces that output low.
- R11: While `rst_n` is 0, every output is 0 and every gate is open, so no output starts out stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_src | input | 1 | Level of the fast source clock |
| cpu_stop_n | input | 1 | Active-low stop request for the pairs |
| cpu_free | input | N_CPU | Per pair: 1 = free-running, 0 = stoppable |
| cpu_en | input | N_CPU | Per pair: 1 = enabled, 0 = forced low and undriven |
| cpu_tri_stop | input | 1 | 1 = stopped pairs release their output enable |
| bus_src | input | 1 | Level of the bus source clock |
| bus_stop_pin_n | input | 1 | Active-low bus stop pin |
| bus_stop_reg | input | 1 | Register bit ANDed with the pin (0 stops) |
| bus_en | input | N_BUS | Per bus output: 1 = enabled, 0 = forced low |
| free_en | input | N_FREE | Per free output: 1 = enabled, 0 = forced low |
| free_stoppable | input | N_FREE | Per free output: 1 = obeys bus stop, 0 = free-running |
| cpu_t | output | N_CPU | True side of each pair |
| cpu_c | output | N_CPU | Complement side of each pair |
| cpu_oe | output | N_CPU | Output enable of each pair |
| bus_out | output | N_BUS | Gated bus clocks |
| free_out | output | N_FREE | Gated free-clock outputs |

## Verification
The bench goes after the cycle in which a stop takes hold. A design that sampled the request on one edge instead of two, or froze the pair while it was low, would show a true output held low or a high pulse cut short. It also releases the request just before a falling edge and measures the restart latency, which catches gates that reopen in the middle of a phase and leave a runt pulse. Other stimulus drops only the register half of the bus stop, which exposes an OR where an AND belongs. Further stimulus flips the free-run, tri-state and enable bits while a stop is active, so that a design mixing up the polarity of one of these bits produces wrong levels or a wrong output enable.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  // Edge found between the previous and the current sampled level.
  function automatic logic edge_seen(input logic prev, input logic cur, input logic on_rise);
    return on_rise ? (~prev & cur) : (prev & ~cur);
  endfunction

  // The gate may only move while the source sits at its resting level.
  function automatic logic hold_gate(input logic src, input logic rest_lvl,
                                     input logic want_run, input logic cur_run);
    return (src == rest_lvl) ? want_run : cur_run;
  endfunction

endpackage

// File: rtl/clkstop_sampler.sv
module clkstop_sampler #(
  parameter int STAGES  = 2,
  parameter bit ON_RISE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic d,
  output logic hit,
  output logic q
);
  import clkstop_pkg::*;

  logic              src_q;
  logic [STAGES-1:0] pipe;

  assign hit = edge_seen(src_q, src, ON_RISE);
  assign q   = pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= 1'b0;
    else        src_q <= src;
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pipe[s] <= 1'b1;
      else if (hit) pipe[s] <= (s == 0) ? d : pipe[(s == 0) ? 0 : s-1];
    end
  end
endmodule

// File: rtl/clkstop_pair.sv
module clkstop_pair (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic req_run,
  input  logic free_run,
  input  logic enable,
  input  logic tri_stop,
  output logic out_t,
  output logic out_c,
  output logic out_oe,
  output logic run
);
  import clkstop_pkg::*;

  logic run_next;

  // Resting level of a pair is true-high, so gating moves only while src is 1.
  assign run_next = hold_gate(src, 1'b1, free_run | req_run, run);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b1;
      out_t  <= 1'b0;
      out_c  <= 1'b0;
      out_oe <= 1'b0;
    end else begin
      run    <= run_next;
      out_t  <= enable & (run_next ? src : 1'b1);
      out_c  <= enable & run_next & ~src;
      out_oe <= enable & (run_next | ~tri_stop);
    end
  end
endmodule

// File: rtl/clkstop_bus.sv
module clkstop_bus #(
  parameter int N_BUS  = 7,
  parameter int N_FREE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src,
  input  logic              req_run,
  input  logic [N_BUS-1:0]  bus_en,
  input  logic [N_FREE-1:0] free_en,
  input  logic [N_FREE-1:0] free_obey,
  output logic [N_BUS-1:0]  bus_out,
  output logic [N_FREE-1:0] free_out,
  output logic              run
);
  import clkstop_pkg::*;

  logic              run_next;
  logic [N_FREE-1:0] free_next;

  // Resting level of the bus group is low, so gating moves only while src is 0.
  assign run_next = hold_gate(src, 1'b0, req_run, run);

  for (genvar k = 0; k < N_FREE; k++) begin : g_free
    assign free_next[k] = free_en[k] & src & (~free_obey[k] | run_next);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b1;
      bus_out  <= '0;
      free_out <= '0;
    end else begin
      run      <= run_next;
      bus_out  <= bus_en & {N_BUS{src & run_next}};
      free_out <= free_next;
    end
  end
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate #(
  parameter int N_CPU     = 3,
  parameter int N_BUS     = 7,
  parameter int N_FREE    = 3,
  parameter int CPU_TAPS  = 2,
  parameter int BUS_TAPS  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_src,
  input  logic              cpu_stop_n,
  input  logic [N_CPU-1:0]  cpu_free,
  input  logic [N_CPU-1:0]  cpu_en,
  input  logic              cpu_tri_stop,
  input  logic              bus_src,
  input  logic              bus_stop_pin_n,
  input  logic              bus_stop_reg,
  input  logic [N_BUS-1:0]  bus_en,
  input  logic [N_FREE-1:0] free_en,
  input  logic [N_FREE-1:0] free_stoppable,
  output logic [N_CPU-1:0]  cpu_t,
  output logic [N_CPU-1:0]  cpu_c,
  output logic [N_CPU-1:0]  cpu_oe,
  output logic [N_BUS-1:0]  bus_out,
  output logic [N_FREE-1:0] free_out
);
  // Named internal events, brought out for the checker.
  logic             cpu_fall;
  logic             cpu_req_run;
  logic             bus_rise;
  logic             bus_req_run;
  logic             bus_eff_run;
  logic [N_CPU-1:0] cpu_run;
  logic             bus_run;

  assign bus_eff_run = bus_stop_pin_n & bus_stop_reg;

  clkstop_sampler #(.STAGES(CPU_TAPS), .ON_RISE(1'b0)) i_cpu_smp (
    .clk(clk), .rst_n(rst_n), .src(cpu_src), .d(cpu_stop_n),
    .hit(cpu_fall), .q(cpu_req_run)
  );

  clkstop_sampler #(.STAGES(BUS_TAPS), .ON_RISE(1'b1)) i_bus_smp (
    .clk(clk), .rst_n(rst_n), .src(bus_src), .d(bus_eff_run),
    .hit(bus_rise), .q(bus_req_run)
  );

  for (genvar i = 0; i < N_CPU; i++) begin : g_pair
    clkstop_pair i_pair (
      .clk(clk), .rst_n(rst_n), .src(cpu_src), .req_run(cpu_req_run),
      .free_run(cpu_free[i]), .enable(cpu_en[i]), .tri_stop(cpu_tri_stop),
      .out_t(cpu_t[i]), .out_c(cpu_c[i]), .out_oe(cpu_oe[i]), .run(cpu_run[i])
    );
  end

  clkstop_bus #(.N_BUS(N_BUS), .N_FREE(N_FREE)) i_bus (
    .clk(clk), .rst_n(rst_n), .src(bus_src), .req_run(bus_req_run),
    .bus_en(bus_en), .free_en(free_en), .free_obey(free_stoppable),
    .bus_out(bus_out), .free_out(free_out), .run(bus_run)
  );
endmodule

// File: rtl/clkstop_gate_chk.sv
module clkstop_gate_chk #(
  parameter int N_CPU  = 3,
  parameter int N_BUS  = 7,
  parameter int N_FREE = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_src,
  input logic [N_CPU-1:0]  cpu_free,
  input logic [N_CPU-1:0]  cpu_en,
  input logic              cpu_tri_stop,
  input logic              bus_src,
  input logic [N_BUS-1:0]  bus_en,
  input logic [N_CPU-1:0]  cpu_t,
  input logic [N_CPU-1:0]  cpu_c,
  input logic [N_CPU-1:0]  cpu_oe,
  input logic [N_BUS-1:0]  bus_out,
  input logic [N_FREE-1:0] free_out,
  input logic              bus_rise,
  input logic              bus_req_run,
  input logic [N_CPU-1:0]  cpu_run,
  input logic              bus_run
);
  for (genvar i = 0; i < N_CPU; i++) begin : g_pair_chk
    AST_PAIR_STOP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_run[i] && $past(cpu_en[i])) |-> (cpu_t[i] && !cpu_c[i])); // R1
    AST_PAIR_FREE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cpu_free[i]) && $past(cpu_src)) |-> cpu_run[i]); // R2
    AST_PAIR_TRI_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_run[i] && $past(cpu_tri_stop)) |-> !cpu_oe[i]); // R3
    AST_PAIR_GATE_AT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cpu_run[i]) |-> $past(cpu_src)); // R5
    AST_PAIR_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cpu_en[i]) |-> (!cpu_oe[i] && !cpu_t[i] && !cpu_c[i])); // R6
  end

  AST_BUS_SAMPLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bus_req_run) |-> $past(bus_rise)); // R7
  AST_BUS_STOPPED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_run |-> (bus_out == '0)); // R7
  AST_BUS_GATE_AT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bus_run) |-> !$past(bus_src)); // R5
  AST_BUS_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_out & ~$past(bus_en)) == '0); // R10
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (cpu_t == '0 && cpu_oe == '0 && bus_out == '0 && free_out == '0)); // R11
endmodule

bind clkstop_gate clkstop_gate_chk #(.N_CPU(N_CPU), .N_BUS(N_BUS), .N_FREE(N_FREE)) i_chk (
  .clk(clk), .rst_n(rst_n), .cpu_src(cpu_src), .cpu_free(cpu_free), .cpu_en(cpu_en),
  .cpu_tri_stop(cpu_tri_stop), .bus_src(bus_src), .bus_en(bus_en),
  .cpu_t(cpu_t), .cpu_c(cpu_c), .cpu_oe(cpu_oe), .bus_out(bus_out), .free_out(free_out),
  .bus_rise(bus_rise), .bus_req_run(bus_req_run), .cpu_run(cpu_run), .bus_run(bus_run)
);

// File: tb/test_clkstop_gate.sv
module test_clkstop_gate;
  localparam int NC = 3;
  localparam int NB = 7;
  localparam int NF = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_src = 1'b0, cpu_stop_n = 1'b1, cpu_tri_stop = 1'b0;
  logic [NC-1:0] cpu_free = '0, cpu_en = '1;
  logic bus_src = 1'b0, bus_stop_pin_n = 1'b1, bus_stop_reg = 1'b1;
  logic [NB-1:0] bus_en = '1;
  logic [NF-1:0] free_en = '1, free_stoppable = '0;
  logic [NC-1:0] cpu_t, cpu_c, cpu_oe;
  logic [NB-1:0] bus_out;
  logic [NF-1:0] free_out;

  int n_tests = 0, n_fail = 0, n_cyc = 0;
  logic [2:0] bcnt = '0;

  // Bench model state: history of stop samples and gate positions.
  logic m_cprev, m_h1, m_h2, m_bprev, m_bsamp, m_brun;
  logic [NC-1:0] m_crun;

  always #2 clk = ~clk;

  clkstop_gate i_clkstop_gate (
    .clk(clk), .rst_n(rst_n), .cpu_src(cpu_src), .cpu_stop_n(cpu_stop_n),
    .cpu_free(cpu_free), .cpu_en(cpu_en), .cpu_tri_stop(cpu_tri_stop),
    .bus_src(bus_src), .bus_stop_pin_n(bus_stop_pin_n), .bus_stop_reg(bus_stop_reg),
    .bus_en(bus_en), .free_en(free_en), .free_stoppable(free_stoppable),
    .cpu_t(cpu_t), .cpu_c(cpu_c), .cpu_oe(cpu_oe), .bus_out(bus_out), .free_out(free_out)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, n_cyc);
    end
  endtask

  // A pair's expected level given whether it is currently passing its source.
  function automatic logic [2:0] pair_exp(input logic en, input logic pass, input logic src, input logic tri_s);
    if (!en) return 3'b000;
    return {pass ? src : 1'b1, pass & ~src, pass | ~tri_s};
  endfunction

  task automatic cycle();
    @(negedge clk);
    if (!rst_n) begin
      m_cprev = 0; m_h1 = 1; m_h2 = 1; m_crun = '1;
      m_bprev = 0; m_bsamp = 1; m_brun = 1;
      check(cpu_t == 0 && cpu_c == 0 && cpu_oe == 0 && bus_out == 0 && free_out == 0,
            "R11", int'({cpu_t, cpu_oe, bus_out}), 0);
    end else begin
      logic [NB-1:0] eb;
      logic [NF-1:0] ef;
      logic bpass;
      for (int i = 0; i < NC; i++) begin
        logic pass;
        logic [2:0] e;
        string tag;
        pass = cpu_src ? (cpu_free[i] | m_h2) : m_crun[i];
        e = pair_exp(cpu_en[i], pass, cpu_src, cpu_tri_stop);
        tag = !cpu_en[i] ? "R6" : cpu_free[i] ? "R2" : (!pass && cpu_tri_stop) ? "R3" :
              !pass ? "R1" : "R5";
        check({cpu_t[i], cpu_c[i], cpu_oe[i]} == e, tag, int'({cpu_t[i], cpu_c[i], cpu_oe[i]}), int'(e));
        m_crun[i] = pass;
      end
      if (m_cprev && !cpu_src) begin m_h2 = m_h1; m_h1 = cpu_stop_n; end
      m_cprev = cpu_src;
      bpass = bus_src ? m_brun : m_bsamp;
      eb = bus_en & {NB{bus_src & bpass}};
      ef = free_en & {NF{bus_src}} & (~free_stoppable | {NF{bpass}});
      check(bus_out == eb, bus_en != '1 ? "R10" : "R7", int'(bus_out), int'(eb));
      check(free_out == ef, "R8", int'(free_out), int'(ef));
      m_brun = bpass;
      if (!m_bprev && bus_src) m_bsamp = bus_stop_pin_n & bus_stop_reg;
      m_bprev = bus_src;
    end
    cpu_src = ~cpu_src;
    bcnt = bcnt + 3'd1;
    bus_src = bcnt[2];
  endtask

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual hang, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'h5eed_c10c));
    for (int k = 0; k < 4; k++) cycle();
    rst_n = 1'b1;

    // Directed: stop all pairs without tri-state, then release (R1, R4).
    cpu_free = '0; cpu_tri_stop = 1'b0; cpu_stop_n = 1'b0;
    for (int k = 0; k < 20; k++) cycle();
    check(cpu_t == '1 && cpu_c == '0, "R1", int'({cpu_t, cpu_c}), int'({3'b111, 3'b000}));
    cpu_stop_n = 1'b1;
    n = 0;
    do begin cycle(); n++; end while (cpu_t[0] && n < 30);
    check(n <= 8, "R4", n, 8);

    // Directed: tri-state on stop with one free pair (R3, R2).
    cpu_tri_stop = 1'b1; cpu_free = 3'b100; cpu_stop_n = 1'b0;
    for (int k = 0; k < 20; k++) cycle();
    check(cpu_oe == 3'b100, "R3", int'(cpu_oe), 4);
    cpu_stop_n = 1'b1; cpu_tri_stop = 1'b0; cpu_free = '0;
    for (int k = 0; k < 12; k++) cycle();

    // Directed: register half of the bus stop alone stops the bus (R7, R8).
    free_stoppable = 3'b010; bus_stop_reg = 1'b0;
    for (int k = 0; k < 40; k++) cycle();
    check(bus_out == '0, "R7", int'(bus_out), 0);
    bus_stop_reg = 1'b1; bus_stop_pin_n = 1'b0;
    for (int k = 0; k < 24; k++) cycle();
    bus_stop_pin_n = 1'b1;
    n = 0;
    do begin cycle(); n++; end while (!bus_out[0] && n < 40);
    check(n <= 18, "R9", n, 18);

    // Directed: enables at zero force outputs low (R6, R10).
    cpu_en = 3'b010; bus_en = 7'h55; free_en = 3'b001;
    for (int k = 0; k < 16; k++) cycle();
    cpu_en = '1; bus_en = '1; free_en = '1;

    // Constrained random phase.
    for (int k = 0; k < 6000; k++) begin
      cycle();
      if ($urandom_range(15) == 0) cpu_stop_n = ~cpu_stop_n;
      if ($urandom_range(31) == 0) bus_stop_pin_n = ~bus_stop_pin_n;
      if ($urandom_range(63) == 0) bus_stop_reg = ~bus_stop_reg;
      if ($urandom_range(199) == 0) begin
        cpu_free = NC'($urandom);
        cpu_en = NC'($urandom) | NC'($urandom);
        cpu_tri_stop = 1'($urandom);
        bus_en = NB'($urandom) | NB'($urandom);
        free_en = NF'($urandom) | NF'($urandom);
        free_stoppable = NF'($urandom);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule